// File: doc/BRIEF.md
# Masked Vector Integer Reduction Unit

This block folds a packed vector operand into a single value. It applies one of eight integer operations, or one of two widening sums, to a scalar seed and to every active element of the vector. The result is the new value of element 0 of the destination register. The surrounding pipeline supplies the vector elements, the per-element mask, the active length (vl), the restart index (vstart), the opcode and the tail policy, and then pulses `start_i`.

The unit runs one operation at a time. It prepares the leaves, passes them through a registered pairwise-combining tree of log2(NUM_ELEM) levels, and raises `done_o` for one cycle at a fixed latency. The same cycle carries `we_o`, which grants the write of `res_o` into element 0. A zero length completes with no write. A nonzero restart index, or an unknown opcode, completes with `ill_o` and no write. The tail-fill flag tells the register file whether the rest of the destination may be overwritten with all ones.

Top module: `vred_unit`

## Requirements
- R1: The opcode `op_i` selects the operation: 0 sum, 1 unsigned max, 2 signed max, 3 unsigned min, 4 signed min, 5 AND, 6 OR, 7 XOR. For these codes the result is that operation over `scalar_i[SEW-1:0]` and all active elements, where element i is `vec_i[i*SEW +: SEW]`.
- R2: The single-width sum wraps modulo 2^SEW, with no saturation. For codes 0 to 7, `res_o[2*SEW-1:SEW]` is zero.
- R3: The scalar always takes part, including when `mask_i[0]` is 0. An element whose mask bit is 0 is excluded from the result.
- R4: An element whose index is vl or higher is excluded, whatever its mask bit.
- R5: Code 8 zero-extends each active element to 2*SEW bits and code 9 sign-extends it. Either code adds the extended elements to the full 2*SEW-bit `scalar_i` and returns the 2*SEW-bit sum.
- R6: With vl equal to 0, the done pulse comes with `we_o` at 0 and `ill_o` at 0.
- R7: A nonzero `vstart_i`, or an opcode from 10 to 15, makes the done pulse carry `ill_o` at 1 and `we_o` at 0.
- R8: `done_o` is high for exactly one cycle, LEVELS+1 cycles after the cycle in which a start is accepted, where LEVELS = log2(NUM_ELEM).
- R9: A start raised from the accepting cycle through the done cycle is ignored. It produces no further done pulse and does not change the result in progress.
- R10: `tail_fill_o` is 1 in the done cycle exactly when `we_o` is 1 and `tail_agn_i` was 1 at the accepted start (1 means agnostic, 0 means undisturbed).
- R11: After reset, `done_o`, `we_o`, `ill_o` and `tail_fill_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| op_i | input | 4 | Operation code |
| vec_i | input | NUM_ELEM*SEW | Packed vector elements, element 0 in the low bits |
| mask_i | input | NUM_ELEM | Per-element enable, 1 = active |
| vl_i | input | log2(NUM_ELEM)+1 | Active length |
| vstart_i | input | log2(NUM_ELEM)+1 | Restart index, must be 0 |
| scalar_i | input | 2*SEW | Scalar seed from element 0; the low SEW bits are used for single-width codes |
| tail_agn_i | input | 1 | Tail policy: 1 agnostic, 0 undisturbed |
| res_o | output | 2*SEW | Value for destination element 0, valid with done_o |
| we_o | output | 1 | Write grant for res_o |
| done_o | output | 1 | One-cycle completion pulse |
| ill_o | output | 1 | Illegal-instruction indication |
| tail_fill_o | output | 1 | Tail elements may be set to all ones |

## Verification
The hardest case to reach is the interaction of the two exclusion rules with the scalar seed. Element 0 must be masked off while the scalar is still counted, and elements past vl must carry set mask bits and extreme values, so that wrongly counting them would visibly change a max, a min or a sum. Directed cases place 0x7F or 0xFF in excluded slots, and they clear every mask bit so that the result must equal the scalar. Random stimulus then mixes lengths from 0 to NUM_ELEM with random masks, occasional nonzero restart indexes and unknown opcodes. Holding start high throughout an operation exercises the busy window.

// File: rtl/vred_pkg.sv
// Package vred_pkg: opcode encoding and opcode-class helpers shared by the
// reduction unit. Assumes 4-bit opcodes with codes 10..15 undefined.
package vred_pkg;

    typedef enum logic [3:0] {
        OP_SUM   = 4'd0,
        OP_MAXU  = 4'd1,
        OP_MAX   = 4'd2,
        OP_MINU  = 4'd3,
        OP_MIN   = 4'd4,
        OP_AND   = 4'd5,
        OP_OR    = 4'd6,
        OP_XOR   = 4'd7,
        OP_WSUMU = 4'd8,
        OP_WSUM  = 4'd9
    } red_op_e;

    // True for the double-width sums
    function automatic logic op_is_wide(logic [3:0] op);
        return (op == OP_WSUMU) || (op == OP_WSUM);
    endfunction

    // True when operands are sign-extended into the datapath
    function automatic logic op_is_signed(logic [3:0] op);
        return (op == OP_MAX) || (op == OP_MIN) || (op == OP_WSUM);
    endfunction

    // True for defined opcodes
    function automatic logic op_is_known(logic [3:0] op);
        return op <= 4'd9;
    endfunction

endpackage

// File: rtl/vred_comb.sv
// Module vred_comb: combines two datapath words under the current opcode.
// Assumes operands are already extended to W bits consistently with the
// opcode's signedness, so one W-bit compare serves both max/min flavours.
module vred_comb
    import vred_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);

    logic a_gt;

    // Greater-than under the opcode's signedness
    always_comb begin
        if (op_is_signed(op_i)) a_gt = $signed(a_i) > $signed(b_i);
        else                    a_gt = a_i > b_i;
    end

    // Select the combining function
    always_comb begin
        case (op_i)
            OP_MAXU, OP_MAX: y_o = a_gt ? a_i : b_i;
            OP_MINU, OP_MIN: y_o = a_gt ? b_i : a_i;
            OP_AND:          y_o = a_i & b_i;
            OP_OR:           y_o = a_i | b_i;
            OP_XOR:          y_o = a_i ^ b_i;
            default:         y_o = a_i + b_i;
        endcase
    end

endmodule

// File: rtl/vred_leaf.sv
// Module vred_leaf: turns raw elements into tree leaves. Inactive elements
// (mask clear or index >= vl) become the opcode's identity; every leaf is
// extended to 2*SEW bits; the scalar seed is folded into leaf 0.
// Assumes NUM_ELEM < 2**CNT_W.
module vred_leaf
    import vred_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int SEW      = 8,
    parameter int CNT_W    = 4,
    localparam int W       = 2 * SEW
) (
    input  logic [3:0]                   op_i,
    input  logic [NUM_ELEM*SEW-1:0]      vec_i,
    input  logic [NUM_ELEM-1:0]          mask_i,
    input  logic [CNT_W-1:0]             vl_i,
    input  logic [W-1:0]                 scalar_i,
    output logic [NUM_ELEM-1:0][W-1:0]   leaves_o
);

    logic [SEW-1:0]                ident;
    logic                          sgn;
    logic [NUM_ELEM-1:0][W-1:0]    ext_w;
    logic [W-1:0]                  scal_ext;
    logic [W-1:0]                  fold0;

    assign sgn = op_is_signed(op_i);

    // Identity value of the opcode at element width
    always_comb begin
        case (op_i)
            OP_AND, OP_MINU: ident = '1;
            OP_MAX:          ident = {1'b1, {(SEW-1){1'b0}}};
            OP_MIN:          ident = {1'b0, {(SEW-1){1'b1}}};
            default:         ident = '0;
        endcase
    end

    // Replace inactive elements and extend each to datapath width
    always_comb begin
        for (int i = 0; i < NUM_ELEM; i++) begin
            logic            act;
            logic [SEW-1:0]  e;
            act      = mask_i[i] && (CNT_W'(i) < vl_i);
            e        = act ? vec_i[i*SEW +: SEW] : ident;
            ext_w[i] = {{SEW{sgn & e[SEW-1]}}, e};
        end
    end

    // Scalar seed: full width for widening sums, extended low half otherwise
    always_comb begin
        if (op_is_wide(op_i)) scal_ext = scalar_i;
        else scal_ext = {{SEW{sgn & scalar_i[SEW-1]}}, scalar_i[SEW-1:0]};
    end

    vred_comb #(.W(W)) u_seed (
        .op_i (op_i),
        .a_i  (scal_ext),
        .b_i  (ext_w[0]),
        .y_o  (fold0)
    );

    // Leaf 0 carries the seed, the others pass through
    always_comb begin
        leaves_o    = ext_w;
        leaves_o[0] = fold0;
    end

endmodule

// File: rtl/vred_tree.sv
// Module vred_tree: registered pairwise-combining tree laid out as a heap.
// Leaves load on load_i; every internal level registers once, so the root
// is valid LEVELS cycles after the leaf load. Assumes NUM_ELEM is a power
// of two, at least 2, and op_i is stable while a reduction is in flight.
module vred_tree #(
    parameter int NUM_ELEM = 8,
    parameter int W        = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [3:0]                  op_i,
    input  logic [NUM_ELEM-1:0][W-1:0]  leaves_i,
    output logic [W-1:0]                root_o
);

    logic [NUM_ELEM-1:0][W-1:0] leaf_q;
    logic [W-1:0]               int_w [NUM_ELEM-1];

    // Capture the prepared leaves at an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)      leaf_q <= '0;
        else if (load_i) leaf_q <= leaves_i;
    end

    for (genvar i = 0; i < NUM_ELEM - 1; i++) begin : g_node
        localparam int LC = 2 * i + 1;
        localparam int RC = 2 * i + 2;
        logic [W-1:0] a, b, y, q;

        if (LC >= NUM_ELEM - 1) begin : g_al
            assign a = leaf_q[LC-(NUM_ELEM-1)];
        end else begin : g_ai
            assign a = int_w[LC];
        end

        if (RC >= NUM_ELEM - 1) begin : g_bl
            assign b = leaf_q[RC-(NUM_ELEM-1)];
        end else begin : g_bi
            assign b = int_w[RC];
        end

        vred_comb #(.W(W)) u_c (
            .op_i (op_i),
            .a_i  (a),
            .b_i  (b),
            .y_o  (y)
        );

        // Register this node's combined pair
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= y;
        end

        assign int_w[i] = q;
    end

    assign root_o = int_w[0];

endmodule

// File: rtl/vred_ctrl.sv
// Module vred_ctrl: accepts a start when idle, latches the operation's
// control attributes, and times the done pulse with a valid shift register
// of LEVELS+1 stages. Assumes LEVELS >= 1.
module vred_ctrl
    import vred_pkg::*;
#(
    parameter int LEVELS = 3,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [3:0]       op_i,
    input  logic [CNT_W-1:0] vl_i,
    input  logic [CNT_W-1:0] vstart_i,
    input  logic             tail_agn_i,
    output logic             accept_o,
    output logic [3:0]       op_q_o,
    output logic             done_o,
    output logic             wr_ok_o,
    output logic             ill_o,
    output logic             tail_o
);

    logic          busy;
    logic [LEVELS:0] vs;

    assign accept_o = start_i && !busy;
    assign done_o   = vs[LEVELS];

    // Busy from acceptance until the done cycle ends
    always_ff @(posedge clk) begin
        if (!rst_n)        busy <= 1'b0;
        else if (accept_o) busy <= 1'b1;
        else if (done_o)   busy <= 1'b0;
    end

    // Track how far the accepted operation has travelled
    always_ff @(posedge clk) begin
        if (!rst_n) vs <= '0;
        else        vs <= {vs[LEVELS-1:0], accept_o};
    end

    // Latch the opcode, legality and tail policy at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q_o  <= '0;
            wr_ok_o <= 1'b0;
            ill_o   <= 1'b0;
            tail_o  <= 1'b0;
        end else if (accept_o) begin
            op_q_o  <= op_i;
            ill_o   <= (vstart_i != '0) || !op_is_known(op_i);
            wr_ok_o <= (vstart_i == '0) && op_is_known(op_i) && (vl_i != '0);
            tail_o  <= tail_agn_i;
        end
    end

endmodule

// File: rtl/vred_unit.sv
// Module vred_unit: masked integer reduction of a vector into element 0.
// One operation in flight; result, write grant and illegal flag are valid
// in the single done cycle. Assumes NUM_ELEM is a power of two >= 2 and
// SEW is 8, 16 or 32.
module vred_unit
    import vred_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int SEW      = 8,
    localparam int LEVELS  = $clog2(NUM_ELEM),
    localparam int CNT_W   = LEVELS + 1,
    localparam int W       = 2 * SEW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [3:0]               op_i,
    input  logic [NUM_ELEM*SEW-1:0]  vec_i,
    input  logic [NUM_ELEM-1:0]      mask_i,
    input  logic [CNT_W-1:0]         vl_i,
    input  logic [CNT_W-1:0]         vstart_i,
    input  logic [W-1:0]             scalar_i,
    input  logic                     tail_agn_i,
    output logic [W-1:0]             res_o,
    output logic                     we_o,
    output logic                     done_o,
    output logic                     ill_o,
    output logic                     tail_fill_o
);

    logic                        accept;
    logic [3:0]                  op_q;
    logic                        done;
    logic                        wr_ok;
    logic                        ill_q;
    logic                        tail_q;
    logic [NUM_ELEM-1:0][W-1:0]  leaves;
    logic [W-1:0]                root;

    vred_ctrl #(.LEVELS(LEVELS), .CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .vl_i       (vl_i),
        .vstart_i   (vstart_i),
        .tail_agn_i (tail_agn_i),
        .accept_o   (accept),
        .op_q_o     (op_q),
        .done_o     (done),
        .wr_ok_o    (wr_ok),
        .ill_o      (ill_q),
        .tail_o     (tail_q)
    );

    vred_leaf #(.NUM_ELEM(NUM_ELEM), .SEW(SEW), .CNT_W(CNT_W)) u_leaf (
        .op_i     (op_i),
        .vec_i    (vec_i),
        .mask_i   (mask_i),
        .vl_i     (vl_i),
        .scalar_i (scalar_i),
        .leaves_o (leaves)
    );

    vred_tree #(.NUM_ELEM(NUM_ELEM), .W(W)) u_tree (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .op_i     (op_q),
        .leaves_i (leaves),
        .root_o   (root)
    );

    // Narrow results occupy the low half only
    always_comb begin
        if (op_is_wide(op_q)) res_o = root;
        else                  res_o = {{SEW{1'b0}}, root[SEW-1:0]};
    end

    assign done_o      = done;
    assign we_o        = done && wr_ok;
    assign ill_o       = done && ill_q;
    assign tail_fill_o = done && wr_ok && tail_q;

endmodule

// File: rtl/vred_unit_chk.sv
// Module vred_unit_chk: port-level checker for vred_unit, bound below.
// Tracks accepted starts on its own to relate latency, length, restart
// index and tail policy to the completion outputs.
module vred_unit_chk #(
    parameter int NUM_ELEM = 8,
    parameter int SEW      = 8,
    localparam int LEVELS  = $clog2(NUM_ELEM),
    localparam int CNT_W   = LEVELS + 1,
    localparam int W       = 2 * SEW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [3:0]       op_i,
    input logic [CNT_W-1:0] vl_i,
    input logic [CNT_W-1:0] vstart_i,
    input logic             tail_agn_i,
    input logic [W-1:0]     res_o,
    input logic             we_o,
    input logic             done_o,
    input logic             ill_o,
    input logic             tail_fill_o
);

    logic             c_busy;
    logic [7:0]       c_cnt;
    logic [CNT_W-1:0] c_vl;
    logic [CNT_W-1:0] c_vs;
    logic [3:0]       c_op;
    logic             c_tail;

    // Shadow of the accepted operation and cycles elapsed since acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_busy <= 1'b0;
            c_cnt  <= '0;
            c_vl   <= '0;
            c_vs   <= '0;
            c_op   <= '0;
            c_tail <= 1'b0;
        end else if (start_i && !c_busy) begin
            c_busy <= 1'b1;
            c_cnt  <= '0;
            c_vl   <= vl_i;
            c_vs   <= vstart_i;
            c_op   <= op_i;
            c_tail <= tail_agn_i;
        end else if (c_busy) begin
            c_cnt <= c_cnt + 8'd1;
            if (done_o) c_busy <= 1'b0;
        end
    end

    assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (c_busy && c_cnt == 8'(LEVELS)));

    assert_done_arrives_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_busy && c_cnt == 8'(LEVELS)) |-> done_o);

    assert_vl_zero_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_vl == '0) |-> !we_o);

    assert_vstart_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_vs != '0) |-> (ill_o && !we_o));

    assert_write_only_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o || ill_o) |-> (done_o && !(we_o && ill_o)));

    assert_tail_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tail_fill_o |-> (we_o && c_tail));

    assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && c_op <= 4'd7) |-> (res_o[W-1:SEW] == '0));

endmodule

bind vred_unit vred_unit_chk #(.NUM_ELEM(NUM_ELEM), .SEW(SEW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_i        (op_i),
    .vl_i        (vl_i),
    .vstart_i    (vstart_i),
    .tail_agn_i  (tail_agn_i),
    .res_o       (res_o),
    .we_o        (we_o),
    .done_o      (done_o),
    .ill_o       (ill_o),
    .tail_fill_o (tail_fill_o)
);

// File: tb/vred_unit_test.sv
`timescale 1ns/1ps
// Bench vred_unit_test: directed corner cases plus seeded random operations,
// each compared with a reference model written from the requirements.
module vred_unit_test;

    localparam int N      = 8;
    localparam int SEW    = 8;
    localparam int LEVELS = $clog2(N);
    localparam int CNT_W  = LEVELS + 1;
    localparam int W      = 2 * SEW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [3:0]        op_i = '0;
    logic [N*SEW-1:0]  vec_i = '0;
    logic [N-1:0]      mask_i = '0;
    logic [CNT_W-1:0]  vl_i = '0;
    logic [CNT_W-1:0]  vstart_i = '0;
    logic [W-1:0]      scalar_i = '0;
    logic              tail_agn_i = 1'b0;
    logic [W-1:0]      res_o;
    logic              we_o, done_o, ill_o, tail_fill_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vred_unit #(.NUM_ELEM(N), .SEW(SEW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .vec_i(vec_i), .mask_i(mask_i), .vl_i(vl_i), .vstart_i(vstart_i),
        .scalar_i(scalar_i), .tail_agn_i(tail_agn_i), .res_o(res_o),
        .we_o(we_o), .done_o(done_o), .ill_o(ill_o), .tail_fill_o(tail_fill_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference result from the requirement text
    function automatic logic [W-1:0] ref_res(input logic [3:0] op,
            input logic [N*SEW-1:0] v, input logic [N-1:0] m,
            input int vl, input logic [W-1:0] sc);
        logic [W-1:0]   acc;
        logic [SEW-1:0] a, e;
        if (op == 4'd8 || op == 4'd9) begin
            acc = sc;
            for (int i = 0; i < N; i++) begin
                e = v[i*SEW +: SEW];
                if (m[i] && i < vl) begin
                    if (op == 4'd9) acc = acc + {{SEW{e[SEW-1]}}, e};
                    else            acc = acc + {{SEW{1'b0}}, e};
                end
            end
            return acc;
        end
        a = sc[SEW-1:0];
        for (int i = 0; i < N; i++) begin
            e = v[i*SEW +: SEW];
            if (m[i] && i < vl) begin
                case (op)
                    4'd0: a = a + e;
                    4'd1: a = (e > a) ? e : a;
                    4'd2: a = ($signed(e) > $signed(a)) ? e : a;
                    4'd3: a = (e < a) ? e : a;
                    4'd4: a = ($signed(e) < $signed(a)) ? e : a;
                    4'd5: a = a & e;
                    4'd6: a = a | e;
                    default: a = a ^ e;
                endcase
            end
        end
        return {{SEW{1'b0}}, a};
    endfunction

    // Issue one operation and check its completion
    task automatic run_op(input string tag, input logic [3:0] op,
            input logic [N*SEW-1:0] v, input logic [N-1:0] m, input int vl,
            input int vs, input logic [W-1:0] sc, input bit tail);
        logic [W-1:0] exp;
        bit exp_ill, exp_we;
        bit early;
        exp_ill = (vs != 0) || (op > 4'd9);
        exp_we  = !exp_ill && (vl != 0);
        exp     = ref_res(op, v, m, vl, sc);
        op_i = op; vec_i = v; mask_i = m; vl_i = CNT_W'(vl);
        vstart_i = CNT_W'(vs); scalar_i = sc; tail_agn_i = tail;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        early = 0;
        for (int k = 1; k <= LEVELS; k++) begin
            if (done_o) early = 1;
            @(negedge clk);
        end
        check(!early && done_o, {tag, " R8 done timing"}, {63'd0, done_o}, 64'd1);
        check(ill_o == exp_ill, {tag, " R7 ill"}, {63'd0, ill_o}, {63'd0, exp_ill});
        check(we_o == exp_we, {tag, " R6 we"}, {63'd0, we_o}, {63'd0, exp_we});
        check(tail_fill_o == (exp_we && tail), {tag, " R10 tail fill"},
              {63'd0, tail_fill_o}, {63'd0, exp_we && tail});
        if (exp_we)
            check(res_o == exp, {tag, " R1 result"}, 64'(res_o), 64'(exp));
        @(negedge clk);
        check(!done_o, {tag, " R8 single pulse"}, {63'd0, done_o}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N*SEW-1:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!done_o && !we_o && !ill_o && !tail_fill_o, "R11 reset outputs",
              {60'd0, done_o, we_o, ill_o, tail_fill_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !we_o, "R11 idle after reset", {62'd0, done_o, we_o}, 64'd0);

        // R2 wrap: eight 0xFF plus 5
        run_op("R2 wrap", 4'd0, {N{8'hFF}}, '1, 8, 0, 16'h0005, 0);
        // R3 everything masked: result is the scalar
        run_op("R3 all masked max", 4'd2, {N{8'h7F}}, '0, 8, 0, 16'h005A, 0);
        run_op("R3 all masked and", 4'd5, {N{8'h00}}, '0, 8, 0, 16'h00C3, 1);
        // R3 element 0 masked off, scalar still counts
        v = '0; v[7:0] = 8'h7F;
        run_op("R3 elem0 masked", 4'd1, v, 8'hFE, 8, 0, 16'h0010, 0);
        // R4 elements past vl hold large values with mask set
        v = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h03, 8'h02, 8'h01};
        run_op("R4 short vl sum", 4'd0, v, '1, 3, 0, 16'h0000, 0);
        run_op("R4 short vl maxu", 4'd1, v, '1, 3, 0, 16'h0000, 1);
        // R1 signed versus unsigned extremes
        v = {8'h80, 8'h7F, 8'h01, 8'hFE, 8'h40, 8'hC0, 8'h00, 8'h10};
        for (int op = 1; op <= 7; op++)
            run_op("R1 extremes", 4'(op), v, 8'hFF, 8, 0, 16'h0005, op[0]);
        // R5 widening sums over -128 elements
        run_op("R5 wsum signed", 4'd9, {N{8'h80}}, '1, 8, 0, 16'h0100, 0);
        run_op("R5 wsum unsigned", 4'd8, {N{8'h80}}, '1, 8, 0, 16'h0100, 1);
        // R6 zero length
        run_op("R6 vl zero", 4'd0, {N{8'h11}}, '1, 0, 0, 16'h0033, 1);
        // R7 restart index and unknown code
        run_op("R7 vstart", 4'd0, {N{8'h11}}, '1, 8, 1, 16'h0033, 1);
        run_op("R7 bad opcode", 4'd12, {N{8'h11}}, '1, 8, 0, 16'h0033, 0);

        // R9 start held high through the whole operation
        begin
            logic [W-1:0] exp9;
            bit extra;
            v = {8'h08, 8'h07, 8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01};
            exp9 = ref_res(4'd0, v, '1, 8, 16'h0001);
            op_i = 4'd0; vec_i = v; mask_i = '1; vl_i = CNT_W'(8);
            vstart_i = '0; scalar_i = 16'h0001; tail_agn_i = 1'b0;
            start_i = 1'b1;
            @(negedge clk);
            vec_i = {N{8'hEE}}; op_i = 4'd6; scalar_i = 16'h00FF;
            for (int k = 1; k <= LEVELS; k++) @(negedge clk);
            check(done_o && res_o == exp9, "R9 busy start ignored",
                  64'(res_o), 64'(exp9));
            @(negedge clk);
            start_i = 1'b0;
            extra = 0;
            for (int k = 0; k < LEVELS + 2; k++) begin
                if (done_o) extra = 1;
                @(negedge clk);
            end
            check(!extra, "R9 no second done", {63'd0, extra}, 64'd0);
        end

        // Random mix
        for (int t = 0; t < 400; t++) begin
            logic [3:0] op;
            int vl, vs;
            op = ($urandom % 20 == 0) ? 4'(10 + $urandom % 6) : 4'($urandom % 10);
            vl = $urandom % (N + 1);
            vs = ($urandom % 16 == 0) ? 1 + $urandom % N : 0;
            v  = {$urandom, $urandom};
            run_op("R1 random", op, v, N'($urandom), vl, vs, W'($urandom),
                   1'($urandom));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule